// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller Core

This block arbitrates eight interrupt request lines for one processor. A rising edge on a request line latches a pending bit. Each pending bit can be blocked by a mask bit. The winning line is found by scanning upward from a programmable base line, wrapping at eight. The block raises its interrupt output when the best unmasked pending line ranks strictly above the best line already in service. When the processor acknowledges, the winning line moves from pending to in service, and the block returns a vector. The vector combines a five-bit base from setup with the three-bit line number.

Software drives the block through a byte-wide interface with one address bit. Address 0 takes the setup start word, the readback and poll controls, and the end-of-service and priority commands. Address 1 takes the remaining setup words and then the mask. Reads at address 0 return pending, in-service, or a poll result. Reads at address 1 return the mask. The interrupt output is registered.

Top module: `irq_prio_top`

## Requirements
- R1: The rank of a line is its distance (line − base) mod 8. Distance 0 is the highest rank. An empty set has rank 8. The winner is the lowest-distance bit of pending AND NOT mask.
- R2: The interrupt output is asserted only when the winner's rank is strictly better than the best in-service rank. An equal or worse rank keeps it low.
- R3: In nested-cascade mode (setup mode word bit 4 = 1), in-service bit 2 is left out of the current-rank calculation.
- R4: A write to address 0 with bit 4 = 1 starts setup. It clears pending, in-service, mask, base, all mode flags and the poll request, and it drops the output. Bit 0 of that write records whether a mode word will follow.
- R5: After setup starts, address-1 writes are taken in order. The first gives the vector base from bits 7:3 (bits 2:0 are dropped). The second is discarded. A third, the mode word, is taken only if the flag from R4 is set: bit 4 selects nested-cascade mode and bit 1 selects auto end-of-service. Later address-1 writes load the mask.
- R6: An address-0 write with bit 4 = 0 and bit 3 = 1 is a control word. When its bit 1 = 1, bit 0 chooses what address-0 reads return: 1 gives in-service, 0 gives pending. Address-1 reads always return the mask.
- R7: An address-0 write with bits 4:3 = 00 is a command, selected by bits 7:5:
  - 1 clears the top-ranked in-service bit.
  - 5 does the same and then sets the base to that line + 1.
  - 3 clears in-service bit (data & 7).
  - 6 sets the base to (data + 1) & 7.
  - 7 clears in-service bit (data & 7) and sets the base to that line + 1.
  - 0 and 4 clear and set the rotate-on-auto flag.
- R8: An acknowledge with a winner clears that line's pending bit and sets its in-service bit. In auto end-of-service mode the in-service bit stays clear, and if the rotate-on-auto flag is set the base becomes line + 1.
- R9: A control word with bit 2 = 1 arms a poll. The next address-0 read returns the winning line number, or 7 when there is no winner, and clears that line's pending and in-service bits. The poll is then disarmed.
- R10: While the acknowledge input is high, the vector output is {vector base, winning line}, with line 7 when there is no winner.
- R11: The interrupt output is a register. It reflects the state one clock after that state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqLines | input | 8 | Request lines; a rising edge sets a pending bit |
| addr | input | 1 | Register address bit |
| wrEn | input | 1 | Single-cycle write strobe |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Single-cycle read strobe |
| rdData | output | 8 | Read data, valid while rdEn is high |
| intAck | input | 1 | Single-cycle acknowledge from the processor |
| ackVector | output | 8 | Vector returned during acknowledge |
| intOut | output | 1 | Registered interrupt request to the processor |

## Verification
The hardest states to reach are arbitrary pending sets under each of the eight base positions. Only edges and single-bit clears change pending, so these states cannot be written directly. The bench sets each base with the priority command. For every nonzero pending pattern it sends one burst of edges, then drains the set by repeated poll reads. Each returned line is compared with an arithmetic scan of the remaining bits, and the final read must return 7. Directed sequences build up in-service stacks through acknowledges to reach the strict-rank, nested-cascade and auto-rotation cases.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int LINES = 8;
  localparam int LW    = $clog2(LINES);
  localparam int DW    = 8;
  localparam int VBW   = DW - LW;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic           clearAll;
    logic           loadMask;
    logic           clrTop;
    logic           clrLine;
    logic           rotate;
    logic           setBase;
    logic           ack;
    logic           pollTake;
    logic [LW-1:0]  cmdLine;
  } dpStrobe_t;

  // configuration and read-side state held by control
  typedef struct packed {
    logic [VBW-1:0] vecBase;
    logic           autoEoi;
    logic           rotAutoEoi;
    logic           sfnMode;
    logic           readIsr;
    logic           pollPend;
  } modeState_t;

  // distance from base to the first set bit; LINES when empty
  function automatic logic [LW:0] scanPrio(input logic [LINES-1:0] vec,
                                           input logic [LW-1:0] base);
    logic [LW:0]   p;
    logic [LW-1:0] idx;
    p = (LW+1)'(LINES);
    for (int i = LINES - 1; i >= 0; i--) begin
      idx = base + LW'(i);
      if (vec[idx]) p = (LW+1)'(i);
    end
    return p;
  endfunction
endpackage

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_prio_pkg::*;
(
  input  logic [LINES-1:0] vec,
  input  logic [LW-1:0]    base,
  output logic [LW:0]      prio,
  output logic [LW-1:0]    line
);
  assign prio = scanPrio(vec, base);
  assign line = base + prio[LW-1:0];
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          addr,
  input  logic          wrEn,
  input  logic [DW-1:0] wrData,
  input  logic          rdEn,
  input  logic          intAck,
  output dpStrobe_t     strobe,
  output modeState_t    mode
);
  typedef enum logic [1:0] {ST_RUN, ST_VEC, ST_SKIP, ST_MODE} initStep_e;

  initStep_e step;
  logic      needMode;
  logic      isCmdWr;
  logic      isDataWr;

  assign isCmdWr  = wrEn && !addr;
  assign isDataWr = wrEn && addr;

  always_comb begin
    strobe          = '0;
    strobe.cmdLine  = wrData[LW-1:0];
    strobe.ack      = intAck;
    strobe.pollTake = rdEn && !addr && mode.pollPend;
    strobe.loadMask = isDataWr && (step == ST_RUN);
    if (isCmdWr && wrData[4]) begin
      strobe.clearAll = 1'b1;
    end else if (isCmdWr && !wrData[3]) begin
      unique case (wrData[7:5])
        3'd1: strobe.clrTop = 1'b1;
        3'd5: begin strobe.clrTop = 1'b1; strobe.rotate = 1'b1; end
        3'd3: strobe.clrLine = 1'b1;
        3'd6: strobe.setBase = 1'b1;
        3'd7: begin strobe.clrLine = 1'b1; strobe.rotate = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step     <= ST_RUN;
      needMode <= 1'b0;
      mode     <= '0;
    end else begin
      if (strobe.pollTake) mode.pollPend <= 1'b0;
      if (isCmdWr) begin
        if (wrData[4]) begin
          mode     <= '0;
          step     <= ST_VEC;
          needMode <= wrData[0];
        end else if (wrData[3]) begin
          if (wrData[2]) mode.pollPend <= 1'b1;
          if (wrData[1]) mode.readIsr  <= wrData[0];
        end else if (wrData[6:5] == 2'b00) begin
          mode.rotAutoEoi <= wrData[7];
        end
      end
      if (isDataWr) begin
        unique case (step)
          ST_VEC: begin
            mode.vecBase <= wrData[DW-1:LW];
            step         <= ST_SKIP;
          end
          ST_SKIP: step <= needMode ? ST_MODE : ST_RUN;
          ST_MODE: begin
            mode.sfnMode <= wrData[4];
            mode.autoEoi <= wrData[1];
            step         <= ST_RUN;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_prio_datapath.sv
module irq_prio_datapath
  import irq_prio_pkg::*;
#(
  parameter int CASCADE_LINE = 2
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] reqLines,
  input  logic [DW-1:0]    wrData,
  input  logic             addr,
  input  dpStrobe_t        strobe,
  input  modeState_t       mode,
  output logic [DW-1:0]    rdData,
  output logic [DW-1:0]    ackVector,
  output logic             intOut,
  output logic [LINES-1:0] irr,
  output logic [LINES-1:0] isr,
  output logic [LINES-1:0] imr,
  output logic             winValid,
  output logic [LW-1:0]    winLine
);
  logic [LINES-1:0] lastReq;
  logic [LW-1:0]    base;
  logic [LINES-1:0] irrN, isrN, imrN, curMask;
  logic [LW-1:0]    baseN;
  logic [LW:0]      pendPrio, topPrio, curPrio;
  logic [LW-1:0]    topLine;
  logic             topValid;

  irq_prio_resolver u_pendRes (
    .vec (irr & ~imr),
    .base(base),
    .prio(pendPrio),
    .line(winLine)
  );

  irq_prio_resolver u_isrRes (
    .vec (isr),
    .base(base),
    .prio(topPrio),
    .line(topLine)
  );

  always_comb begin
    curMask = isr;
    if (mode.sfnMode) curMask[CASCADE_LINE] = 1'b0;
  end

  assign curPrio  = scanPrio(curMask, base);
  assign topValid = !topPrio[LW];
  assign winValid = pendPrio < curPrio;

  always_comb begin
    irrN  = irr;
    isrN  = isr;
    imrN  = imr;
    baseN = base;
    if (strobe.ack && winValid) begin
      irrN[winLine] = 1'b0;
      if (mode.autoEoi) begin
        if (mode.rotAutoEoi) baseN = winLine + 1'b1;
      end else begin
        isrN[winLine] = 1'b1;
      end
    end
    if (strobe.pollTake && winValid) begin
      irrN[winLine] = 1'b0;
      isrN[winLine] = 1'b0;
    end
    if (strobe.clrTop && topValid) begin
      isrN[topLine] = 1'b0;
      if (strobe.rotate) baseN = topLine + 1'b1;
    end
    if (strobe.clrLine) begin
      isrN[strobe.cmdLine] = 1'b0;
      if (strobe.rotate) baseN = strobe.cmdLine + 1'b1;
    end
    if (strobe.setBase) baseN = strobe.cmdLine + 1'b1;
    if (strobe.loadMask) imrN = wrData;
    irrN = irrN | (reqLines & ~lastReq);
    if (strobe.clearAll) begin
      irrN  = '0;
      isrN  = '0;
      imrN  = '0;
      baseN = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irr     <= '0;
      isr     <= '0;
      imr     <= '0;
      base    <= '0;
      lastReq <= '0;
      intOut  <= 1'b0;
    end else begin
      irr     <= irrN;
      isr     <= isrN;
      imr     <= imrN;
      base    <= baseN;
      lastReq <= reqLines;
      intOut  <= winValid && !strobe.clearAll;
    end
  end

  always_comb begin
    if (!addr && mode.pollPend)
      rdData = winValid ? DW'(winLine) : DW'(LINES - 1);
    else if (!addr)
      rdData = mode.readIsr ? isr : irr;
    else
      rdData = imr;
  end

  assign ackVector = {mode.vecBase, winValid ? winLine : LW'(LINES - 1)};
endmodule

// File: rtl/irq_prio_top.sv
module irq_prio_top
  import irq_prio_pkg::*;
#(
  parameter int CASCADE_LINE = 2
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] reqLines,
  input  logic             addr,
  input  logic             wrEn,
  input  logic [DW-1:0]    wrData,
  input  logic             rdEn,
  output logic [DW-1:0]    rdData,
  input  logic             intAck,
  output logic [DW-1:0]    ackVector,
  output logic             intOut
);
  dpStrobe_t        strobe;
  modeState_t       mode;
  logic [LINES-1:0] irr, isr, imr;
  logic             winValid;
  logic [LW-1:0]    winLine;
  logic             autoEoiQ, pollPendQ;

  assign autoEoiQ  = mode.autoEoi;
  assign pollPendQ = mode.pollPend;

  irq_prio_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .addr  (addr),
    .wrEn  (wrEn),
    .wrData(wrData),
    .rdEn  (rdEn),
    .intAck(intAck),
    .strobe(strobe),
    .mode  (mode)
  );

  irq_prio_datapath #(.CASCADE_LINE(CASCADE_LINE)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .reqLines (reqLines),
    .wrData   (wrData),
    .addr     (addr),
    .strobe   (strobe),
    .mode     (mode),
    .rdData   (rdData),
    .ackVector(ackVector),
    .intOut   (intOut),
    .irr      (irr),
    .isr      (isr),
    .imr      (imr),
    .winValid (winValid),
    .winLine  (winLine)
  );
endmodule

// File: rtl/irq_prio_checker.sv
module irq_prio_checker
  import irq_prio_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [LINES-1:0] reqLines,
  input logic             addr,
  input logic             wrEn,
  input logic [DW-1:0]    wrData,
  input logic             rdEn,
  input logic             intAck,
  input logic [DW-1:0]    ackVector,
  input logic             intOut,
  input logic [LINES-1:0] irr,
  input logic [LINES-1:0] isr,
  input logic [LINES-1:0] imr,
  input logic             winValid,
  input logic [LW-1:0]    winLine,
  input logic             autoEoiQ,
  input logic             pollPendQ
);
  // R2: a winner needs an unmasked pending bit
  p_win_needs_pending_r2: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> |(irr & ~imr));

  // R11: output follows the winner one clock later unless setup started
  p_out_latency_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrEn && !addr && wrData[4]) |-> intOut == $past(winValid));

  // R10: vector low bits are 7 when nothing wins
  p_spurious_vec_r10: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !winValid) |-> ackVector[LW-1:0] == LW'(LINES - 1));

  // R8: acknowledge without auto end-of-service marks the line in service
  p_ack_sets_isr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && winValid && !autoEoiQ && !wrEn) |=> isr[$past(winLine)]);

  // R8: acknowledge in auto end-of-service mode leaves in-service unchanged
  p_auto_eoi_r8: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && winValid && autoEoiQ && !wrEn && !rdEn) |=> $stable(isr));

  // R9: a poll read drops the winning pending bit
  p_poll_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !addr && pollPendQ && winValid && !wrEn && !reqLines[winLine])
      |=> !irr[$past(winLine)]);

  // R9: the poll request is gone after the read that uses it
  p_poll_once_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !addr && pollPendQ && !wrEn) |=> !pollPendQ);
endmodule

bind irq_prio_top irq_prio_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqLines (reqLines),
  .addr     (addr),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .rdEn     (rdEn),
  .intAck   (intAck),
  .ackVector(ackVector),
  .intOut   (intOut),
  .irr      (irr),
  .isr      (isr),
  .imr      (imr),
  .winValid (winValid),
  .winLine  (winLine),
  .autoEoiQ (autoEoiQ),
  .pollPendQ(pollPendQ)
);

// File: tb/test_irq_prio_top.sv
`timescale 1ns/1ps
module test_irq_prio_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] reqLines = '0;
  logic       addr = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic       intAck = 1'b0;
  logic [7:0] ackVector;
  logic       intOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_prio_top i_irq_prio_top (
    .clk(clk), .rstN(rstN), .reqLines(reqLines), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .intAck(intAck),
    .ackVector(ackVector), .intOut(intOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1; #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk); intAck = 1'b1; #1 v = ackVector;
    @(negedge clk); intAck = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] p);
    @(negedge clk); reqLines = p;
    @(negedge clk); reqLines = '0;
  endtask

  task automatic poll(output logic [7:0] v);
    wr(1'b0, 8'h0C);
    rd(1'b0, v);
  endtask

  task automatic setup(input logic [7:0] vec, input bit withMode, input logic [7:0] mw);
    wr(1'b0, withMode ? 8'h11 : 8'h10);
    wr(1'b1, vec);
    wr(1'b1, 8'h00);
    if (withMode) wr(1'b1, mw);
    wr(1'b1, 8'h00);
  endtask

  function automatic logic [2:0] winOf(input logic [7:0] p, input logic [2:0] b);
    for (int i = 0; i < 8; i++) begin
      logic [2:0] idx;
      idx = b + 3'(i);
      if (p[idx]) return idx;
    end
    return 3'd7;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 reset out", intOut, 0);
    rd(1'b1, v); chk("R6 reset mask", v, 0);
    rd(1'b0, v); chk("R6 reset pending", v, 0);

    // vector base 0x47 keeps only bits 7:3
    setup(8'h47, 1, 8'h00);
    @(negedge clk); reqLines = 8'h08;
    @(negedge clk); reqLines = '0;
    chk("R11 out not yet", intOut, 0);
    @(negedge clk);
    chk("R11 out one later", intOut, 1);
    ack(v); chk("R10 R5 vector line3", v, 8'h43);
    @(negedge clk); chk("R2 same line blocked", intOut, 0);
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R6 R8 isr after ack", v, 8'h08);
    wr(1'b0, 8'h0A); rd(1'b0, v); chk("R8 pending cleared", v, 8'h00);
    pulse(8'h20); @(negedge clk); @(negedge clk);
    chk("R2 lower rank blocked", intOut, 0);
    pulse(8'h02); @(negedge clk);
    chk("R2 higher rank passes", intOut, 1);
    ack(v); chk("R10 vector line1", v, 8'h41);
    wr(1'b0, 8'h20);
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R7 nonspecific eoi", v, 8'h08);
    @(negedge clk); chk("R2 still blocked by 3", intOut, 0);
    wr(1'b0, 8'h63); @(negedge clk); @(negedge clk);
    chk("R7 specific eoi releases", intOut, 1);
    rd(1'b0, v); chk("R7 isr empty", v, 8'h00);
    ack(v); chk("R10 vector line5", v, 8'h45);
    wr(1'b0, 8'hA0);
    rd(1'b0, v); chk("R7 rotating eoi clears", v, 8'h00);
    pulse(8'h41);
    poll(v); chk("R7 rotated base first", v, 6);
    poll(v); chk("R7 rotated base second", v, 0);
    poll(v); chk("R9 empty poll", v, 7);
    wr(1'b0, 8'h0A); rd(1'b0, v); chk("R9 poll disarmed", v, 8'h00);
    wr(1'b0, 8'hC2);
    wr(1'b0, 8'hE1);
    pulse(8'h07);
    poll(v); chk("R7 specific rotate order a", v, 2);
    poll(v); chk("R7 specific rotate order b", v, 0);
    poll(v); chk("R7 specific rotate order c", v, 1);

    wr(1'b1, 8'hFF); rd(1'b1, v); chk("R6 mask read", v, 8'hFF);
    pulse(8'h10); @(negedge clk); @(negedge clk);
    chk("R1 masked no output", intOut, 0);
    ack(v); chk("R10 spurious vector", v, 8'h47);
    wr(1'b1, 8'h00); @(negedge clk); @(negedge clk);
    chk("R1 unmasked output", intOut, 1);
    poll(v); chk("R9 poll line4", v, 4);

    // R4 setup clears state
    wr(1'b1, 8'h5A); pulse(8'h40);
    wr(1'b0, 8'h10);
    @(negedge clk); chk("R4 output dropped", intOut, 0);
    rd(1'b1, v); chk("R4 mask cleared", v, 0);
    rd(1'b0, v); chk("R4 pending cleared", v, 0);
    wr(1'b1, 8'h80); wr(1'b1, 8'hAA); wr(1'b1, 8'h33);
    rd(1'b1, v); chk("R5 no mode word", v, 8'h33);
    wr(1'b1, 8'h00);
    pulse(8'h01); ack(v); chk("R5 vector base 0x80", v, 8'h80);

    // R3 nested-cascade mode
    setup(8'h00, 1, 8'h10);
    pulse(8'h04); @(negedge clk); ack(v); chk("R3 ack line2", v, 2);
    pulse(8'h10); @(negedge clk); @(negedge clk);
    chk("R3 line4 passes over isr2", intOut, 1);
    ack(v); chk("R3 ack line4", v, 4);

    // R8 auto end-of-service with rotation
    setup(8'h20, 1, 8'h02);
    wr(1'b0, 8'h80);
    pulse(8'h02); @(negedge clk); @(negedge clk);
    ack(v); chk("R8 auto vector", v, 8'h21);
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R8 auto isr empty", v, 0);
    pulse(8'h03);
    poll(v); chk("R8 rotated first", v, 0);
    poll(v); chk("R8 rotated second", v, 1);
    wr(1'b0, 8'h00);
    pulse(8'h20); @(negedge clk); ack(v); chk("R8 auto no rotate vec", v, 8'h25);
    pulse(8'h0A);
    poll(v); chk("R8 base held first", v, 3);
    poll(v); chk("R8 base held second", v, 1);

    // R1 R9 sweep: every base, every pattern, drained by polls
    setup(8'h00, 0, 8'h00);
    for (int b = 0; b < 8; b++) begin
      wr(1'b0, 8'hC0 | 8'((b + 7) & 7));
      for (int p = 1; p < 256; p++) begin
        logic [7:0] rem;
        logic [2:0] w;
        rem = 8'(p);
        pulse(rem);
        while (rem != 0) begin
          w = winOf(rem, 3'(b));
          poll(v);
          chk("R1 R9 sweep winner", v, int'(w));
          rem[w] = 1'b0;
        end
        poll(v);
        chk("R9 sweep drained", v, 7);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule